// File: doc/BRIEF.md
# Quad-Wire Page Program Handler

This block is the memory-side receiver for a page-program transaction on a four-wire serial memory link. The host lowers chip select and sends an 8-bit opcode and a 24-bit address one bit per serial clock on data line 0. It then sends data bytes as nibble pairs spread over all four lines. The serial lines are synchronised into the system clock domain, and serial-clock rising edges are found there. Opcode and address bits go into shift registers. Data bytes go into a page buffer with one valid bit per byte column. The column starts at the low address byte and wraps inside the page.

When chip select is released, the handler decides whether the transaction may run. The release must fall on a whole-byte boundary with at least one data byte sent. The quad-enable bit and the write-enable latch must both be set, and the target page must lie outside the block-protected region. If all of these hold, the handler drives a one-clock array-write pulse carrying the page number, the buffer and the byte mask. It then holds write-in-progress high for a programmable number of system clocks. The downstream array is expected to AND the new data into the old contents at the masked columns. A one-byte write-enable command sets the latch.

Top module: `qspi_pgm_handler`

## Requirements
- R1: After reset, status bits 0 (write-in-progress) and 1 (write-enable latch) read 0, and `arr_we_o` is low.
- R2: A transaction of exactly eight header bits with opcode 0x06 (MSB first on `io_i[0]`) sets status bit 1 when chip select rises.
- R3: A run with opcode 0x32 gives a one-clock `arr_we_o` pulse. The address is sent MSB first on `io_i[0]`. The run must end after whole data bytes, with status bit 9 (quad enable) and bit 1 set, outside protection. During the pulse, `arr_page_o` is the address shifted right by eight. Byte n sits at `arr_data_o[8*c +: 8]` with c = (address[7:0] + n) mod 256. The high nibble comes first on `io_i[3:0]`, then the low nibble.
- R4: During the pulse, `arr_mask_o` bit c is 1 exactly for the columns written in that transaction.
- R5: When more than 256 data bytes are sent, the column wraps within the page, later bytes replace earlier ones, and all 256 mask bits are set.
- R6: A chip-select release after an odd number of data nibbles starts no program and leaves the write-enable latch unchanged.
- R7: A chip-select release after the address with no data byte starts no program.
- R8: With quad enable (`qe_i`, status bit 9) at 0, no program starts.
- R9: With the write-enable latch at 0, no program starts.
- R10: With protect field value b (`bp_i`, status bits 6:2) nonzero, pages at or above 65536 − b·2048 are refused. The page just below the boundary is accepted.
- R11: At the pulse the write-enable latch is already 0, and write-in-progress stays 1 for exactly PROG_CYCLES system clocks.
- R12: While write-in-progress is 1, write-enable and program transactions have no effect.
- R13: A transaction with any other opcode, even one followed by data, starts no program and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, data sampled on its rising edge |
| io_i | input | 4 | Serial data lines (inputs only) |
| qe_i | input | 1 | Quad-enable bit loaded into the status register |
| bp_i | input | 5 | Block-protect field loaded into the status register |
| status_o | output | 16 | Status: bit0 busy, bit1 write-enable latch, bits 6:2 protect, bit9 quad enable |
| arr_we_o | output | 1 | One-clock array-write strobe |
| arr_page_o | output | 16 | Page number for the array write |
| arr_data_o | output | 2048 | Page buffer, byte c at bits 8c+7..8c |
| arr_mask_o | output | 256 | Per-column write mask |

## Verification
The bench sends 260 bytes starting two columns before the end of a page. A handler that did not wrap would write outside the page or keep the first bytes, which shows up as column mismatches or an incomplete mask. Releases after a stray nibble and right after the address must produce no strobe. A handler that counted bits instead of completed bytes would program a truncated byte. The protect boundary is probed one page on each side, which catches an off-by-one compare. A second write-enable and program sent while the first cycle is still running exposes a handler that re-arms its latch or restarts while busy.

// File: rtl/qspi_pgm_pkg.sv
package qspi_pgm_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_QPP  = 8'h32;
  localparam int OP_BITS   = 8;
  localparam int ADDR_BITS = 24;
  localparam int HDR_BITS  = OP_BITS + ADDR_BITS;
  localparam int HDR_CW    = $clog2(HDR_BITS + 1);
endpackage

// File: rtl/qspi_sync.sv
module qspi_sync (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic [3:0] io_i,
  output logic       cs_hi_o,
  output logic       cs_rise_o,
  output logic       sclk_rise_o,
  output logic [3:0] io_o
);
  logic [2:0] cs_q, sck_q;
  logic [3:0] io_q1, io_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '1;
      sck_q <= '0;
      io_q1 <= '0;
      io_q2 <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_ni};
      sck_q <= {sck_q[1:0], sclk_i};
      io_q1 <= io_i;
      io_q2 <= io_q1;
    end
  end

  assign cs_hi_o     = cs_q[1];
  assign cs_rise_o   = cs_q[1] & ~cs_q[2];
  assign sclk_rise_o = sck_q[1] & ~sck_q[2] & ~cs_q[1];
  assign io_o        = io_q2;
endmodule

// File: rtl/qspi_pgm_rx.sv
module qspi_pgm_rx import qspi_pgm_pkg::*; #(
  parameter int PAGE_BYTES = 256,
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_BITS - COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_hi_i,
  input  logic                    sclk_rise_i,
  input  logic [3:0]              io_i,
  output logic [7:0]              op_o,
  output logic [PAGE_W-1:0]       page_o,
  output logic [HDR_CW-1:0]       hdr_cnt_o,
  output logic                    nib_odd_o,
  output logic                    has_byte_o,
  output logic [8*PAGE_BYTES-1:0] buf_o,
  output logic [PAGE_BYTES-1:0]   mask_o
);
  logic [7:0]           op_q;
  logic [ADDR_BITS-1:0] addr_q;
  logic [HDR_CW-1:0]    hdr_cnt_q;
  logic [COL_W-1:0]     col_q;
  logic [3:0]           hi_q;
  logic                 nib_odd_q, has_byte_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]           buf_q [PAGE_BYTES];

  logic in_hdr, in_data, byte_wr;
  assign in_hdr  = hdr_cnt_q < HDR_CW'(HDR_BITS);
  assign in_data = !in_hdr && (op_q == OP_QPP);
  assign byte_wr = sclk_rise_i && in_data && nib_odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= '0;
      addr_q     <= '0;
      hdr_cnt_q  <= '0;
      col_q      <= '0;
      hi_q       <= '0;
      nib_odd_q  <= 1'b0;
      has_byte_q <= 1'b0;
      mask_q     <= '0;
    end else if (cs_hi_i) begin
      // mask, op and address stay for the array-write port
      hdr_cnt_q  <= '0;
      nib_odd_q  <= 1'b0;
      has_byte_q <= 1'b0;
    end else if (sclk_rise_i) begin
      if (in_hdr) begin
        hdr_cnt_q <= hdr_cnt_q + 1'b1;
        if (hdr_cnt_q < HDR_CW'(OP_BITS)) op_q <= {op_q[6:0], io_i[0]};
        else                              addr_q <= {addr_q[ADDR_BITS-2:0], io_i[0]};
        if (hdr_cnt_q == HDR_CW'(HDR_BITS - 1)) begin
          col_q  <= {addr_q[COL_W-2:0], io_i[0]};
          mask_q <= '0;
        end
      end else if (in_data) begin
        nib_odd_q <= ~nib_odd_q;
        if (!nib_odd_q) begin
          hi_q <= io_i;
        end else begin
          has_byte_q    <= 1'b1;
          mask_q[col_q] <= 1'b1;
          col_q         <= col_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (byte_wr && !cs_hi_i) buf_q[col_q] <= {hi_q, io_i};
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign buf_o[8*g +: 8] = buf_q[g];
  end

  assign op_o       = op_q;
  assign page_o     = addr_q[ADDR_BITS-1:COL_W];
  assign hdr_cnt_o  = hdr_cnt_q;
  assign nib_odd_o  = nib_odd_q;
  assign has_byte_o = has_byte_q;
  assign mask_o     = mask_q;

  // a byte counts only when its second nibble lands
  assert_byte_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(has_byte_q) |-> $fell(nib_odd_q));
  // mask bits only appear during a data phase
  assert_mask_in_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mask_q) > $countones($past(mask_q))) |-> $past(in_data));
endmodule

// File: rtl/qspi_pgm_ctrl.sv
module qspi_pgm_ctrl import qspi_pgm_pkg::*; #(
  parameter int PAGE_W      = 16,
  parameter int PROG_CYCLES = 1024,
  parameter int PROT_SHIFT  = 11,
  localparam int TMR_W = $clog2(PROG_CYCLES + 1),
  localparam int PW    = PAGE_W + 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_rise_i,
  input  logic [7:0]        op_i,
  input  logic [HDR_CW-1:0] hdr_cnt_i,
  input  logic              nib_odd_i,
  input  logic              has_byte_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              qe_i,
  input  logic [4:0]        bp_i,
  output logic              start_o,
  output logic              wip_o,
  output logic              wel_o
);
  localparam logic [PW-1:0] TOP = {{5{1'b0}}, 1'b1, {PAGE_W{1'b0}}};

  logic             busy_q, wel_q, start_q;
  logic [TMR_W-1:0] tmr_q;
  logic [PW-1:0]    span;
  logic             prot_hit, wren_ok, pgm_ok;

  // protected region grows downward from the top page
  assign span     = PW'(bp_i) << PROT_SHIFT;
  assign prot_hit = (bp_i != '0) && ((PW'(page_i) + span) >= TOP);

  assign wren_ok = cs_rise_i && !busy_q && (op_i == OP_WREN) &&
                   (hdr_cnt_i == HDR_CW'(OP_BITS));
  assign pgm_ok  = cs_rise_i && !busy_q && (op_i == OP_QPP) &&
                   (hdr_cnt_i == HDR_CW'(HDR_BITS)) && !nib_odd_i && has_byte_i &&
                   qe_i && wel_q && !prot_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wel_q   <= 1'b0;
      start_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      start_q <= pgm_ok;
      if (pgm_ok) begin
        busy_q <= 1'b1;
        wel_q  <= 1'b0;
        tmr_q  <= TMR_W'(PROG_CYCLES - 1);
      end else begin
        if (busy_q) begin
          if (tmr_q == '0) busy_q <= 1'b0;
          else             tmr_q  <= tmr_q - 1'b1;
        end
        if (wren_ok) wel_q <= 1'b1;
      end
    end
  end

  assign start_o = start_q;
  assign wip_o   = busy_q;
  assign wel_o   = wel_q;

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  assert_wel_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (busy_q && !wel_q));
  assert_no_restart_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> !$past(busy_q));
  assert_no_wel_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !wel_q);
endmodule

// File: rtl/qspi_pgm_handler.sv
module qspi_pgm_handler import qspi_pgm_pkg::*; #(
  parameter int PAGE_BYTES  = 256,
  parameter int PROG_CYCLES = 1024,
  parameter int PROT_SHIFT  = 11,
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_BITS - COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    sclk_i,
  input  logic [3:0]              io_i,
  input  logic                    qe_i,
  input  logic [4:0]              bp_i,
  output logic [15:0]             status_o,
  output logic                    arr_we_o,
  output logic [PAGE_W-1:0]       arr_page_o,
  output logic [8*PAGE_BYTES-1:0] arr_data_o,
  output logic [PAGE_BYTES-1:0]   arr_mask_o
);
  logic              cs_hi, cs_rise, sclk_rise;
  logic [3:0]        io_s;
  logic [7:0]        op;
  logic [HDR_CW-1:0] hdr_cnt;
  logic              nib_odd, has_byte, wip, wel;
  logic              qe_q;
  logic [4:0]        bp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qe_q <= 1'b0;
      bp_q <= '0;
    end else begin
      qe_q <= qe_i;
      bp_q <= bp_i;
    end
  end

  qspi_sync u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .io_i,
    .cs_hi_o(cs_hi), .cs_rise_o(cs_rise), .sclk_rise_o(sclk_rise), .io_o(io_s)
  );

  qspi_pgm_rx #(.PAGE_BYTES(PAGE_BYTES)) u_rx (
    .clk_i, .rst_ni, .cs_hi_i(cs_hi), .sclk_rise_i(sclk_rise), .io_i(io_s),
    .op_o(op), .page_o(arr_page_o), .hdr_cnt_o(hdr_cnt), .nib_odd_o(nib_odd),
    .has_byte_o(has_byte), .buf_o(arr_data_o), .mask_o(arr_mask_o)
  );

  qspi_pgm_ctrl #(.PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES), .PROT_SHIFT(PROT_SHIFT)) u_ctrl (
    .clk_i, .rst_ni, .cs_rise_i(cs_rise), .op_i(op), .hdr_cnt_i(hdr_cnt),
    .nib_odd_i(nib_odd), .has_byte_i(has_byte), .page_i(arr_page_o),
    .qe_i(qe_q), .bp_i(bp_q), .start_o(arr_we_o), .wip_o(wip), .wel_o(wel)
  );

  assign status_o = {6'b0, qe_q, 2'b0, bp_q, wel, wip};

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> status_o[0]);
endmodule

// File: tb/sim_qspi_pgm_handler.sv
module sim_qspi_pgm_handler;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int PROG = 1500;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, qe = 1'b0;
  logic [3:0] io = '0;
  logic [4:0] bp = '0;
  logic [15:0] status;
  logic arr_we;
  logic [15:0] arr_page;
  logic [2047:0] arr_data;
  logic [255:0] arr_mask;

  int checks = 0, errors = 0;
  int pulses = 0, wip_cycles = 0;
  logic [15:0] cap_page;
  logic [2047:0] cap_data;
  logic [255:0] cap_mask;
  logic [7:0] tx [300];
  logic [7:0] exp_byte [256];
  logic [255:0] exp_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_pgm_handler #(.PROG_CYCLES(PROG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .io_i(io),
    .qe_i(qe), .bp_i(bp), .status_o(status), .arr_we_o(arr_we),
    .arr_page_o(arr_page), .arr_data_o(arr_data), .arr_mask_o(arr_mask)
  );

  always @(posedge clk) begin
    if (arr_we) begin
      pulses   <= pulses + 1;
      cap_page <= arr_page;
      cap_data <= arr_data;
      cap_mask <= arr_mask;
    end
    if (status[0]) wip_cycles <= wip_cycles + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  task automatic spi_clk(input logic [3:0] v);
    io = v;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_up();
    tick(HALF);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic ser_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_clk({3'b0, b[i]});
  endtask

  task automatic wren();
    cs_lo();
    ser_byte(8'h06);
    cs_up();
  endtask

  // sends op + addr + n bytes from tx, optional stray nibble
  task automatic xfer(input logic [7:0] op, input logic [23:0] a, input int n, input bit stray);
    cs_lo();
    ser_byte(op);
    ser_byte(a[23:16]);
    ser_byte(a[15:8]);
    ser_byte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      spi_clk(tx[i][7:4]);
      spi_clk(tx[i][3:0]);
    end
    if (stray) spi_clk(4'hA);
    cs_up();
  endtask

  task automatic fill(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) tx[i] = 8'(i * 7) ^ seed;
  endtask

  task automatic check_page(input string req, input logic [23:0] a, input int n);
    int mism = 0;
    exp_mask = '0;
    for (int i = 0; i < n; i++) begin
      exp_byte[8'(a[7:0] + 8'(i))] = tx[i];
      exp_mask[8'(a[7:0] + 8'(i))] = 1'b1;
    end
    for (int c = 0; c < 256; c++)
      if (exp_mask[c] && cap_data[8*c +: 8] !== exp_byte[c]) mism++;
    chk({req, " page"}, 32'(cap_page), 32'(a[23:8]));
    chk({req, " data mismatches"}, mism, 0);
    chk({"R4 mask diff bits"}, $countones(cap_mask ^ exp_mask), 0);
  endtask

  task automatic wait_idle();
    while (status[0]) tick(1);
    tick(2);
  endtask

  task automatic t_reset();
    chk("R1 wip", 32'(status[0]), 0);
    chk("R1 wel", 32'(status[1]), 0);
    chk("R1 arr_we", 32'(arr_we), 0);
  endtask

  task automatic t_wren();
    wren();
    chk("R2 wel set", 32'(status[1]), 1);
  endtask

  task automatic t_basic();
    int p0, w0;
    qe = 1'b1;
    tick(2);
    fill(3, 8'hA5);
    p0 = pulses;
    w0 = wip_cycles;
    xfer(8'h32, 24'h012345, 3, 1'b0);
    chk("R3 one pulse", pulses - p0, 1);
    check_page("R3", 24'h012345, 3);
    chk("R11 wel cleared", 32'(status[1]), 0);
    chk("R11 wip high", 32'(status[0]), 1);
    wait_idle();
    chk("R11 wip length", wip_cycles - w0, PROG);
  endtask

  task automatic t_wrong_op();
    int p0 = pulses;
    wren();
    fill(2, 8'h11);
    xfer(8'h02, 24'h000400, 2, 1'b0);
    chk("R13 no pulse", pulses - p0, 0);
    chk("R13 wel kept", 32'(status[1]), 1);
  endtask

  task automatic t_mid_byte();
    int p0 = pulses;
    fill(2, 8'h22);
    xfer(8'h32, 24'h000500, 2, 1'b1);
    chk("R6 no pulse", pulses - p0, 0);
    chk("R6 wel kept", 32'(status[1]), 1);
  endtask

  task automatic t_no_data();
    int p0 = pulses;
    xfer(8'h32, 24'h000600, 0, 1'b0);
    chk("R7 no pulse", pulses - p0, 0);
  endtask

  task automatic t_no_qe();
    int p0 = pulses;
    qe = 1'b0;
    tick(2);
    fill(1, 8'h33);
    xfer(8'h32, 24'h000700, 1, 1'b0);
    chk("R8 no pulse", pulses - p0, 0);
    qe = 1'b1;
    tick(2);
  endtask

  task automatic t_protect();
    int p0 = pulses;
    bp = 5'd1;
    tick(2);
    fill(1, 8'h44);
    xfer(8'h32, 24'hF80010, 1, 1'b0);
    chk("R10 protected refused", pulses - p0, 0);
    xfer(8'h32, 24'hF7FF00, 1, 1'b0);
    chk("R10 boundary accepted", pulses - p0, 1);
    chk("R10 page", 32'(cap_page), 32'h0000F7FF);
    wait_idle();
    bp = 5'd0;
    tick(2);
  endtask

  task automatic t_no_wel();
    int p0 = pulses;
    fill(1, 8'h55);
    xfer(8'h32, 24'h000800, 1, 1'b0);
    chk("R9 no pulse", pulses - p0, 0);
  endtask

  task automatic t_wrap();
    int p0 = pulses;
    wren();
    fill(260, 8'h5A);
    xfer(8'h32, 24'h0200FE, 260, 1'b0);
    chk("R5 one pulse", pulses - p0, 1);
    check_page("R5", 24'h0200FE, 260);
    chk("R5 full mask", $countones(cap_mask), 256);
    wait_idle();
  endtask

  task automatic t_busy();
    int p0 = pulses;
    wren();
    fill(1, 8'h66);
    xfer(8'h32, 24'h000100, 1, 1'b0);
    chk("R12 first pulse", pulses - p0, 1);
    wren();
    chk("R12 wel ignored", 32'(status[1]), 0);
    xfer(8'h32, 24'h000200, 1, 1'b0);
    chk("R12 still busy", 32'(status[0]), 1);
    chk("R12 no restart", pulses - p0, 1);
    wait_idle();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_wren();
    t_basic();
    t_wren();
    t_wrong_op();
    t_mid_byte();
    t_no_data();
    t_no_qe();
    t_protect();
    t_no_wel();
    t_wrap();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule